// File: doc/BRIEF.md
# Scrambled AMI Line Codec

This block turns a serial burst bit stream into three-level symbols for a line driver. Each payload bit first goes through a 9-stage self-synchronizing scrambler with feedback x^9 + x^5 + 1. A scrambled 1 becomes a mark (a pulse) and a scrambled 0 becomes a space. Marks alternate between positive and negative polarity. The polarity of the last mark is kept across bursts, so alternation never breaks at a burst boundary. A burst opens with a start bit. The start bit is always a mark, it bypasses the scrambler, and its polarity is the opposite of the last mark sent.

The receive half is a matching AMI decoder and descrambler, used for loopback checking. It turns received symbols back into line bits and descrambles them, and it needs no alignment step. It raises a one-cycle flag whenever two marks in a row have the same polarity. The flag does not change the recovered data. The transmit and receive halves share the clock and reset but are otherwise independent, so the receive inputs can be fed from the transmit outputs or driven directly.

Top module: `ami_line_codec`

## Requirements
- R1: After reset the line outputs and all receive outputs are low, and both halves treat the last mark as positive, so the first mark after reset is negative.
- R2: `line_pos` and `line_neg` are never high together. A space, an idle cycle (neither `tx_start` nor `tx_valid`) and a scrambled 0 all give both low.
- R3: Every mark has the opposite polarity to the mark before it. This holds across payload bits, start bits and bursts.
- R4: A cycle with `tx_start` high produces a mark on the line in the next cycle, whatever `tx_bit` is, and does not advance the scrambler.
- R5: For a payload cycle (`tx_valid` high, `tx_start` low), the line bit is `tx_bit ^ s[5] ^ s[9]`, where s[1] is the most recent line bit of earlier payload cycles. The line bit is then shifted into s. It appears as a symbol one cycle later.
- R6: When `tx_start` and `tx_valid` are high in the same cycle, the cycle is a start bit and the payload bit is dropped.
- R7: For a receive payload cycle (`rx_valid` high, `rx_start` low), one cycle later `rx_data_valid` is high and `rx_data` = line bit ^ d[5] ^ d[9]. Here the line bit is `rx_pos | rx_neg` and d holds earlier received payload line bits. The descrambler does not advance in any other cycle.
- R8: However the two halves' states differ, once the decoder has taken 9 payload bits from the encoder, every later recovered bit equals the bit the encoder was given.
- R9: `rx_bpv` pulses one cycle after a start or payload cycle whose mark has the same polarity as the previous received mark (`rx_neg` high means negative). The pulse does not change `rx_data`, and `rx_bpv` stays low after any cycle that is neither a start nor a payload cycle.
- R10: A receive start cycle produces no `rx_data_valid`, but its mark updates the receive polarity tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Current cycle is a burst start bit |
| tx_valid | input | 1 | Current cycle carries a payload bit |
| tx_bit | input | 1 | Payload bit |
| line_pos | output | 1 | Positive pulse select |
| line_neg | output | 1 | Negative pulse select |
| rx_start | input | 1 | Received cycle is a start bit |
| rx_valid | input | 1 | Received cycle is a payload bit |
| rx_pos | input | 1 | Received positive pulse |
| rx_neg | input | 1 | Received negative pulse |
| rx_data_valid | output | 1 | Recovered bit valid |
| rx_data | output | 1 | Recovered payload bit |
| rx_bpv | output | 1 | Bipolar violation flag |

## Verification
The hardest case to reach is a decoder whose descrambler and polarity state no longer match the encoder. In plain loopback the two halves stay in lockstep from reset, so self-synchronization and violations never show. The bench therefore switches the receive inputs to directly injected symbols. It forces same-polarity marks and feeds garbage payload bits into the descrambler. It then injects one resynchronizing mark so the polarities line up again and goes back to loopback. It expects the first nine recovered bits to be arbitrary and every later bit to match the transmitted data.

// File: rtl/ami_pkg.sv
// Shared types and sizes for the scrambled AMI line codec.
package ami_pkg;
    // Two-bit symbol drive: {positive, negative}
    typedef enum logic [1:0] {
        SYM_SPACE = 2'b00,
        SYM_NEG   = 2'b01,
        SYM_POS   = 2'b10
    } ami_sym_e;

    // Default scrambler geometry: x^9 + x^5 + 1
    localparam int unsigned SCR_LEN_DEF = 9;
    localparam int unsigned SCR_TAP_DEF = 5;

    // Symbol for a mark that must follow a mark of the given polarity
    function automatic ami_sym_e mark_after(input logic prev_was_neg);
        return prev_was_neg ? SYM_POS : SYM_NEG;
    endfunction
endpackage

// File: rtl/ami_scr_core.sv
// Self-synchronizing scrambler/descrambler core.
// Output is din XOR the stages at positions TAP and LEN (1-based, stage 1 newest).
// FEED_OUT=1 shifts in the output (scrambler); FEED_OUT=0 shifts in din (descrambler).
// Assumes adv is high only for payload bits; the state holds otherwise.
module ami_scr_core #(
    parameter int unsigned LEN      = ami_pkg::SCR_LEN_DEF,
    parameter int unsigned TAP      = ami_pkg::SCR_TAP_DEF,
    parameter bit          FEED_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic din,
    output logic dout
);
    localparam int unsigned TI = TAP - 1;
    localparam int unsigned LI = LEN - 1;

    logic [LEN-1:0] state;
    logic           feed;

    // Combinational scramble/descramble of the current bit
    always_comb dout = din ^ state[TI] ^ state[LI];

    // Pick the shift-in source for this variant
    generate
        if (FEED_OUT) begin : g_scr
            always_comb feed = dout;
        end else begin : g_dscr
            always_comb feed = din;
        end
    endgenerate

    // Shift register advancing only on payload bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (adv) begin
            state <= {state[LEN-2:0], feed};
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state)); // R4
endmodule

// File: rtl/ami_encoder.sv
// AMI encoder with scrambled payload and unscrambled start mark.
// Assumes tx_start marks the burst start bit; tx_valid marks payload bits.
// Start has priority; outputs are registered (one cycle latency).
module ami_encoder #(
    parameter int unsigned SCR_LEN = ami_pkg::SCR_LEN_DEF,
    parameter int unsigned SCR_TAP = ami_pkg::SCR_TAP_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_start,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic line_pos,
    output logic line_neg
);
    import ami_pkg::*;

    logic     adv;
    logic     scr_bit;
    logic     mark;
    logic     last_neg;
    ami_sym_e sym_nxt;

    ami_scr_core #(.LEN(SCR_LEN), .TAP(SCR_TAP), .FEED_OUT(1'b1)) u_scr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .din  (tx_bit),
        .dout (scr_bit)
    );

    // Decide whether this cycle emits a mark, and which polarity
    always_comb begin
        adv     = tx_valid & ~tx_start;
        mark    = tx_start | (adv & scr_bit);
        sym_nxt = mark ? mark_after(last_neg) : SYM_SPACE;
    end

    // Register symbol and remember last mark polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_pos <= 1'b0;
            line_neg <= 1'b0;
            last_neg <= 1'b0;
        end else begin
            line_pos <= sym_nxt[1];
            line_neg <= sym_nxt[0];
            if (mark) last_neg <= ~last_neg;
        end
    end

    AST_EXCLUSIVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg)); // R2
    AST_IDLE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_start && !tx_valid) |=> (!line_pos && !line_neg)); // R2
    AST_START_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (line_pos || line_neg)); // R4
endmodule

// File: rtl/ami_decoder.sv
// AMI decoder with descrambler and bipolar-violation flag.
// Assumes rx_pos and rx_neg are not both high; rx_neg high means a negative mark.
// Outputs are registered one cycle after the receive slot.
module ami_decoder #(
    parameter int unsigned SCR_LEN = ami_pkg::SCR_LEN_DEF,
    parameter int unsigned SCR_TAP = ami_pkg::SCR_TAP_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_start,
    input  logic rx_valid,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic rx_data_valid,
    output logic rx_data,
    output logic rx_bpv
);
    logic adv;
    logic slot;
    logic mark;
    logic dscr_bit;
    logic viol;
    logic last_neg;

    ami_scr_core #(.LEN(SCR_LEN), .TAP(SCR_TAP), .FEED_OUT(1'b0)) u_dscr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .din  (mark),
        .dout (dscr_bit)
    );

    // Classify the received slot and check polarity alternation
    always_comb begin
        slot = rx_start | rx_valid;
        adv  = rx_valid & ~rx_start;
        mark = rx_pos | rx_neg;
        viol = slot & mark & (rx_neg == last_neg);
    end

    // Register recovered data, flag, and last mark polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_valid <= 1'b0;
            rx_data       <= 1'b0;
            rx_bpv        <= 1'b0;
            last_neg      <= 1'b0;
        end else begin
            rx_data_valid <= adv;
            rx_data       <= adv & dscr_bit;
            rx_bpv        <= viol;
            if (slot && mark) last_neg <= rx_neg;
        end
    end

    AST_START_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !rx_data_valid); // R10
    AST_PAYLOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_start) |=> rx_data_valid); // R7
    AST_BPV_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_start || rx_valid) |=> !rx_bpv); // R9
endmodule

// File: rtl/ami_line_codec.sv
// Top level: scrambled AMI encoder plus loopback decoder.
// The two halves share only clock and reset; the receive inputs are free.
module ami_line_codec #(
    parameter int unsigned SCR_LEN = ami_pkg::SCR_LEN_DEF,
    parameter int unsigned SCR_TAP = ami_pkg::SCR_TAP_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_start,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic line_pos,
    output logic line_neg,
    input  logic rx_start,
    input  logic rx_valid,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic rx_data_valid,
    output logic rx_data,
    output logic rx_bpv
);
    ami_encoder #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_start(tx_start),
        .tx_valid(tx_valid),
        .tx_bit  (tx_bit),
        .line_pos(line_pos),
        .line_neg(line_neg)
    );

    ami_decoder #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_start     (rx_start),
        .rx_valid     (rx_valid),
        .rx_pos       (rx_pos),
        .rx_neg       (rx_neg),
        .rx_data_valid(rx_data_valid),
        .rx_data      (rx_data),
        .rx_bpv       (rx_bpv)
    );
endmodule

// File: tb/ami_line_codec_tb.sv
module ami_line_codec_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic tx_start = 0, tx_valid = 0, tx_bit = 0;
    logic line_pos, line_neg;
    logic rx_start, rx_valid, rx_pos, rx_neg;
    logic rx_data_valid, rx_data, rx_bpv;

    logic inject = 0;
    logic inj_s = 0, inj_v = 0, inj_p = 0, inj_n = 0;
    logic lb_s = 0, lb_v = 0;

    // Loopback alignment: slot flags follow the line symbol by one cycle
    always @(posedge clk) begin
        lb_s <= tx_start;
        lb_v <= tx_valid;
    end
    assign rx_start = inject ? inj_s : lb_s;
    assign rx_valid = inject ? inj_v : lb_v;
    assign rx_pos   = inject ? inj_p : line_pos;
    assign rx_neg   = inject ? inj_n : line_neg;

    ami_line_codec u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_start(tx_start), .tx_valid(tx_valid), .tx_bit(tx_bit),
        .line_pos(line_pos), .line_neg(line_neg),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .rx_data_valid(rx_data_valid), .rx_data(rx_data), .rx_bpv(rx_bpv)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic       dat_q[$];
    int         skip = 0;

    logic [8:0] m_sr = '0;
    logic [8:0] m_dr = '0;
    logic       m_tx_neg = 0;
    logic       m_rx_neg = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor for the line and loopback data
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({line_pos, line_neg} == e, t, "line symbol", {line_pos, line_neg}, e);
        end
        if (!inject && rst_n) begin
            if (rx_bpv) check(1'b0, "R9", "unexpected violation", 2'b01, 2'b00);
            if (rx_data_valid) begin
                if (dat_q.size() == 0) begin
                    check(1'b0, "R7", "data without payload", 2'b01, 2'b00);
                end else begin
                    logic d;
                    d = dat_q.pop_front();
                    if (skip > 0) skip--;
                    else check(rx_data == d, skip_tag, "recovered bit", {1'b0, rx_data}, {1'b0, d});
                end
            end
        end
    end

    string skip_tag = "R7";

    task automatic send_start(input logic b, input bit with_valid, input string t);
        @(negedge clk);
        tx_start = 1; tx_valid = with_valid; tx_bit = b;
        exp_q.push_back(m_tx_neg ? 2'b10 : 2'b01);
        tag_q.push_back(t);
        m_tx_neg = ~m_tx_neg;
        m_rx_neg = m_tx_neg;
    endtask

    task automatic send_bit(input logic d, input string t);
        logic s;
        @(negedge clk);
        tx_start = 0; tx_valid = 1; tx_bit = d;
        s = d ^ m_sr[4] ^ m_sr[8];
        m_sr = {m_sr[7:0], s};
        m_dr = {m_dr[7:0], s};
        exp_q.push_back(s ? (m_tx_neg ? 2'b10 : 2'b01) : 2'b00);
        tag_q.push_back(t);
        if (s) begin
            m_tx_neg = ~m_tx_neg;
            m_rx_neg = m_tx_neg;
        end
        dat_q.push_back(d);
    endtask

    task automatic idle(input int n, input string t);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_start = 0; tx_valid = 0; tx_bit = 1;
            exp_q.push_back(2'b00);
            tag_q.push_back(t);
        end
    endtask

    // Injected receive slot with inline expectation from the bench model
    task automatic rx_inj(input logic s, input logic v, input logic p, input logic n,
                          input string t);
        logic slot, mark, bpv, dv, d;
        @(negedge clk);
        tx_start = 0; tx_valid = 0; tx_bit = 0;
        exp_q.push_back(2'b00);
        tag_q.push_back("R2");
        inj_s = s; inj_v = v; inj_p = p; inj_n = n;
        slot = s | v;
        mark = p | n;
        bpv  = slot & mark & (n == m_rx_neg);
        if (slot && mark) m_rx_neg = n;
        dv = v & ~s;
        d  = mark ^ m_dr[4] ^ m_dr[8];
        if (dv) m_dr = {m_dr[7:0], mark};
        @(posedge clk);
        #2;
        check(rx_bpv == bpv, t, "bpv", {1'b0, rx_bpv}, {1'b0, bpv});
        check(rx_data_valid == dv, t, "data valid", {1'b0, rx_data_valid}, {1'b0, dv});
        if (dv) check(rx_data == d, t, "data", {1'b0, rx_data}, {1'b0, d});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #2;
        check({line_pos, line_neg} == 2'b00, "R1", "line after reset", {line_pos, line_neg}, 2'b00);
        check({rx_data_valid, rx_bpv} == 2'b00, "R1", "rx after reset", {rx_data_valid, rx_bpv}, 2'b00);

        // R1/R4: first start mark is negative; R2: zeros from zero state give spaces
        send_start(1'b0, 0, "R1");
        for (int i = 0; i < 36; i++) send_bit(1'b0, "R2");
        idle(6, "R2");
        // R3/R4: next start alternates from previous start
        send_start(1'b1, 0, "R3");
        for (int i = 0; i < 36; i++) send_bit(1'b1, "R5");
        idle(6, "R2");
        send_start(1'b0, 0, "R4");
        for (int i = 0; i < 36; i++) send_bit(i[0], "R5");
        idle(6, "R2");
        for (int b = 0; b < 4; b++) begin
            send_start($urandom_range(0, 1), 0, "R3");
            for (int i = 0; i < 36; i++) send_bit($urandom_range(0, 1), "R5");
            idle(6, "R3");
        end
        // R6: start and payload together act as a start only
        send_start(1'b1, 1, "R6");
        for (int i = 0; i < 12; i++) send_bit($urandom_range(0, 1), "R6");
        idle(4, "R2");

        // Direct injection: violations and start slots
        @(negedge clk);
        inject = 1; inj_s = 0; inj_v = 0; inj_p = 0; inj_n = 0;
        tx_start = 0; tx_valid = 0;
        exp_q.push_back(2'b00); tag_q.push_back("R2");
        rx_inj(1, 0, m_rx_neg ? 1'b0 : 1'b1, m_rx_neg, "R9");
        rx_inj(1, 0, ~m_rx_neg, m_rx_neg, "R10");
        rx_inj(0, 1, 1, 0, "R9");
        rx_inj(0, 1, 1, 0, "R9");
        rx_inj(0, 1, 0, 1, "R7");
        rx_inj(0, 1, 0, 0, "R7");
        rx_inj(0, 0, 1, 0, "R9");
        rx_inj(1, 1, 1, 0, "R10");
        // Garbage payload bits to unalign the descrambler, alternating marks
        for (int i = 0; i < 14; i++) begin
            logic mk;
            mk = $urandom_range(0, 1);
            rx_inj(0, 1, mk & m_rx_neg, mk & ~m_rx_neg, "R7");
        end
        if (m_rx_neg != m_tx_neg) rx_inj(1, 0, m_rx_neg, ~m_rx_neg, "R10");
        rx_inj(0, 0, 0, 0, "R9");
        rx_inj(0, 0, 0, 0, "R9");
        @(negedge clk);
        inject = 0;
        tx_start = 0; tx_valid = 0;
        exp_q.push_back(2'b00); tag_q.push_back("R2");
        skip = 9;
        skip_tag = "R8";
        send_start(1'b0, 0, "R3");
        for (int i = 0; i < 36; i++) send_bit($urandom_range(0, 1), "R8");
        idle(8, "R2");
        @(posedge clk);
        #3;
        check(exp_q.size() == 0 && dat_q.size() == 0, "R7", "queues drained",
              2'(dat_q.size()), 2'b00);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule